// File: doc/BRIEF.md
# Fetch and Load-Accumulator Sequencer

This block is the control half of a small 8-bit accumulator processor. The address space is 12 bits wide, split into a 4-bit page and an 8-bit offset. The block is a clocked state machine. In every cycle it drives the single-bit command lines of the datapath and a 3-bit ALU function code. The datapath makes no decisions of its own; it only carries out the commands it receives. The controller changes state on the rising clock edge. The datapath registers update on the falling edge of the same clock, half a cycle later, so every command is stable for the whole half cycle before it is acted on.

The block sequences the two-step instruction fetch. It then decodes the opcode in the upper four bits of the instruction register. For the direct-address load instruction it runs three more steps:
- it fetches a pointer byte at the next program address;
- it forms an address from the instruction's low nibble (page) and that byte (offset);
- it reads the operand through the ALU into the accumulator.

Any other opcode goes straight back to fetch. The program counter therefore advances twice for a load and once for every other instruction.

In this document, "internal bus" is the datapath's byte bus that feeds the ALU A side and the address register offset. "External bus" is the memory data bus.

Top module: `fetch_lda_seq`

## Requirements
- R1: When `rst_n` is sampled low at a rising edge, the following cycle asserts only `pc_clear`, with every other line and `alu_fn` at 0. The first rising edge with `rst_n` high moves to fetch step 1.
- R2: Fetch step 1 asserts exactly `pc_to_page_bus`, `pc_to_ofs_bus`, `mar_load_page`, `mar_load_ofs` and `pc_inc`, and `alu_fn` is 3'b000. The next cycle is always fetch step 2.
- R3: Fetch step 2 asserts exactly `mar_to_abus`, `mem_read`, `xbus_to_ibus` and `ir_load`, with `alu_fn` = 3'b100 (pass A side).
- R4: At the rising edge that ends fetch step 2, the block compares `ir_word[7:4]` with 4'b0000. On a match it enters pointer step 1. On any other value it enters fetch step 1.
- R5: Pointer step 1 drives the same lines as fetch step 1 (a second program counter increment), and is always followed by pointer step 2.
- R6: Pointer step 2 asserts exactly `mar_to_abus`, `mem_read`, `xbus_to_ibus`, `ibus_to_ofs_bus`, `ir_to_page_bus`, `mar_load_page` and `mar_load_ofs`, with `alu_fn` 3'b000. It is always followed by the operand step.
- R7: The operand step asserts exactly `mar_to_abus`, `mem_read`, `xbus_to_ibus` and `acc_load`, with `alu_fn` = 3'b100. It is always followed by fetch step 1.
- R8: `shift_left`, `shift_right`, `acc_clear`, `pc_load_page`, `pc_load_ofs`, `sr_load`, `sr_carry_flip`, `pc_ofs_to_ibus`, `alu_to_ibus` and `ibus_to_xbus` stay 0 in every cycle.
- R9: At most one driver is enabled per cycle on each of three buses: the address page bus, the address offset bus and the internal bus.
- R10: `flags`, `ir_word[3:0]`, and `ir_word` outside the edge that ends fetch step 2, have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the datapath; the controller uses the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ir_word | input | IR_W (8) | Instruction register contents |
| flags | input | FLAG_W (4) | Status register contents (not used by this sequence) |
| alu_fn | output | 3 | ALU function code; 3'b100 passes the A side |
| acc_load | output | 1 | Load the accumulator from the shifter output |
| acc_clear | output | 1 | Clear the accumulator |
| ir_load | output | 1 | Load the instruction register |
| pc_inc | output | 1 | Increment the program counter |
| pc_load_page | output | 1 | Load the program counter page |
| pc_load_ofs | output | 1 | Load the program counter offset |
| pc_clear | output | 1 | Clear the program counter |
| mar_load_page | output | 1 | Load the address register page from the page bus |
| mar_load_ofs | output | 1 | Load the address register offset from the offset bus |
| sr_load | output | 1 | Load the status register |
| sr_carry_flip | output | 1 | Invert the stored carry flag |
| pc_to_page_bus | output | 1 | Drive the program counter page onto the page bus |
| ir_to_page_bus | output | 1 | Drive the instruction register low nibble onto the page bus |
| pc_to_ofs_bus | output | 1 | Drive the program counter offset onto the offset bus |
| ibus_to_ofs_bus | output | 1 | Drive the internal bus onto the offset bus |
| pc_ofs_to_ibus | output | 1 | Drive the program counter offset onto the internal bus |
| alu_to_ibus | output | 1 | Drive the shifter output onto the internal bus |
| xbus_to_ibus | output | 1 | Drive the external data bus onto the internal bus |
| mar_to_abus | output | 1 | Drive the address register onto the memory address bus |
| ibus_to_xbus | output | 1 | Drive the internal bus onto the external data bus |
| shift_left | output | 1 | Arithmetic shift left in the shifter |
| shift_right | output | 1 | Arithmetic shift right in the shifter |
| mem_read | output | 1 | Memory read strobe |

## Verification
The bench builds the block with the default parameters: an 8-bit instruction word, a 4-bit opcode, 4-bit flags and the load opcode at 0.

These values bring several cases within reach:
- the opcode boundary between 4'h0 and its neighbours 4'h1 and 4'hF;
- instruction words whose low nibble is all ones, all zeros or mixed, which must leave the sequence unchanged;
- every flag pattern.

The bench compares the whole command vector every cycle. This covers back-to-back loads, non-load opcodes and a reset that cuts into the middle of a load.

// File: rtl/fetch_lda_pkg.sv
// Package: shared state encoding, ALU codes and the command bundle
// for the fetch and load-accumulator sequencer.
// Assumes a 3-bit ALU code in which 3'b100 passes the A side.
package fetch_lda_pkg;

    localparam int ALU_W = 3;

    localparam logic [ALU_W-1:0] ALU_IDLE   = 3'b000;
    localparam logic [ALU_W-1:0] ALU_PASS_A = 3'b100;

    typedef enum logic [2:0] {
        ST_PC_CLR    = 3'd0,
        ST_FETCH_ADR = 3'd1,
        ST_FETCH_RD  = 3'd2,
        ST_PTR_ADR   = 3'd3,
        ST_PTR_RD    = 3'd4,
        ST_OPERAND   = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic [ALU_W-1:0] alu_fn;
        logic acc_load;
        logic acc_clear;
        logic ir_load;
        logic pc_inc;
        logic pc_load_page;
        logic pc_load_ofs;
        logic pc_clear;
        logic mar_load_page;
        logic mar_load_ofs;
        logic sr_load;
        logic sr_carry_flip;
        logic pc_to_page_bus;
        logic ir_to_page_bus;
        logic pc_to_ofs_bus;
        logic ibus_to_ofs_bus;
        logic pc_ofs_to_ibus;
        logic alu_to_ibus;
        logic xbus_to_ibus;
        logic mar_to_abus;
        logic ibus_to_xbus;
        logic shift_left;
        logic shift_right;
        logic mem_read;
    } ctl_lines_t;

endpackage

// File: rtl/fls_state_reg.sv
// Module: state register of the sequencer.
// Holds the current step. A synchronous active-low reset forces the
// program-counter clear step. Updates on the rising edge.
module fls_state_reg
    import fetch_lda_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_e nxt_state,
    output seq_state_e cur_state
);

    // Purpose: advance to the next step, or hold the clear step in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_state <= ST_PC_CLR;
        end else begin
            cur_state <= nxt_state;
        end
    end

endmodule

// File: rtl/fls_opcode_match.sv
// Module: opcode comparator.
// Flags when the top OPC_W bits of the instruction word equal LOAD_OPC.
// Assumes OPC_W is smaller than IR_W. The low bits are routed to the
// datapath elsewhere and are not used here.
module fls_opcode_match #(
    parameter int IR_W     = 8,
    parameter int OPC_W    = 4,
    parameter int LOAD_OPC = 0
) (
    input  logic [IR_W-1:0] ir_word,
    output logic            is_load
);

    localparam int OPC_LSB = IR_W - OPC_W;
    localparam logic [OPC_W-1:0] LOAD_CODE = OPC_W'(LOAD_OPC);

    logic [OPC_W-1:0] opcode;
    logic             unused_low_bits;

    assign opcode          = ir_word[IR_W-1:OPC_LSB];
    assign unused_low_bits = ^ir_word[OPC_LSB-1:0];

    // Purpose: compare the opcode field with the load code.
    always_comb begin
        is_load = (opcode == LOAD_CODE);
    end

endmodule

// File: rtl/fls_next_state.sv
// Module: next-step logic.
// The only branch is at the end of fetch step 2, where the opcode
// comparator picks between the pointer steps and a new fetch.
module fls_next_state
    import fetch_lda_pkg::*;
(
    input  seq_state_e cur_state,
    input  logic       is_load,
    output seq_state_e nxt_state
);

    // Purpose: select the step that follows the current one.
    always_comb begin
        unique case (cur_state)
            ST_PC_CLR:    nxt_state = ST_FETCH_ADR;
            ST_FETCH_ADR: nxt_state = ST_FETCH_RD;
            ST_FETCH_RD:  nxt_state = is_load ? ST_PTR_ADR : ST_FETCH_ADR;
            ST_PTR_ADR:   nxt_state = ST_PTR_RD;
            ST_PTR_RD:    nxt_state = ST_OPERAND;
            ST_OPERAND:   nxt_state = ST_FETCH_ADR;
            default:      nxt_state = ST_PC_CLR;
        endcase
    end

endmodule

// File: rtl/fls_ctl_decode.sv
// Module: command decoder.
// Maps each step to its datapath command bundle. Every line starts at
// 0 and only the lines a step needs are raised, so each bus has at
// most one driver in any step.
module fls_ctl_decode
    import fetch_lda_pkg::*;
(
    input  seq_state_e cur_state,
    output ctl_lines_t ctl
);

    // Purpose: raise the command lines of the current step over an all-zero default.
    always_comb begin
        ctl = '0;
        unique case (cur_state)
            ST_PC_CLR: begin
                ctl.pc_clear = 1'b1;
            end
            ST_FETCH_ADR, ST_PTR_ADR: begin
                ctl.pc_to_page_bus = 1'b1;
                ctl.pc_to_ofs_bus  = 1'b1;
                ctl.mar_load_page  = 1'b1;
                ctl.mar_load_ofs   = 1'b1;
                ctl.pc_inc         = 1'b1;
            end
            ST_FETCH_RD: begin
                ctl.mar_to_abus  = 1'b1;
                ctl.mem_read     = 1'b1;
                ctl.xbus_to_ibus = 1'b1;
                ctl.alu_fn       = ALU_PASS_A;
                ctl.ir_load      = 1'b1;
            end
            ST_PTR_RD: begin
                ctl.mar_to_abus     = 1'b1;
                ctl.mem_read        = 1'b1;
                ctl.xbus_to_ibus    = 1'b1;
                ctl.ibus_to_ofs_bus = 1'b1;
                ctl.ir_to_page_bus  = 1'b1;
                ctl.mar_load_page   = 1'b1;
                ctl.mar_load_ofs    = 1'b1;
            end
            ST_OPERAND: begin
                ctl.mar_to_abus  = 1'b1;
                ctl.mem_read     = 1'b1;
                ctl.xbus_to_ibus = 1'b1;
                ctl.alu_fn       = ALU_PASS_A;
                ctl.acc_load     = 1'b1;
            end
            default: begin
                ctl.alu_fn = ALU_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/fetch_lda_seq.sv
// Module: fetch and load-accumulator sequencer (top).
// Drives the datapath commands for instruction fetch and for the
// direct-address load. Changes state on the rising edge. Assumes the
// datapath registers update on the falling edge of the same clock.
// The status flags are carried through the port but not used.
module fetch_lda_seq
    import fetch_lda_pkg::*;
#(
    parameter int IR_W     = 8,
    parameter int OPC_W    = 4,
    parameter int FLAG_W   = 4,
    parameter int LOAD_OPC = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IR_W-1:0]   ir_word,
    input  logic [FLAG_W-1:0] flags,
    output logic [ALU_W-1:0]  alu_fn,
    output logic              acc_load,
    output logic              acc_clear,
    output logic              ir_load,
    output logic              pc_inc,
    output logic              pc_load_page,
    output logic              pc_load_ofs,
    output logic              pc_clear,
    output logic              mar_load_page,
    output logic              mar_load_ofs,
    output logic              sr_load,
    output logic              sr_carry_flip,
    output logic              pc_to_page_bus,
    output logic              ir_to_page_bus,
    output logic              pc_to_ofs_bus,
    output logic              ibus_to_ofs_bus,
    output logic              pc_ofs_to_ibus,
    output logic              alu_to_ibus,
    output logic              xbus_to_ibus,
    output logic              mar_to_abus,
    output logic              ibus_to_xbus,
    output logic              shift_left,
    output logic              shift_right,
    output logic              mem_read
);

    localparam int OPC_LSB = IR_W - OPC_W;
    localparam logic [OPC_W-1:0] LOAD_CODE = OPC_W'(LOAD_OPC);

    seq_state_e cur_state;
    seq_state_e nxt_state;
    logic       is_load;
    ctl_lines_t ctl;
    logic       unused_flags;

    assign unused_flags = ^flags;

    fls_opcode_match #(
        .IR_W     (IR_W),
        .OPC_W    (OPC_W),
        .LOAD_OPC (LOAD_OPC)
    ) u_opc (
        .ir_word (ir_word),
        .is_load (is_load)
    );

    fls_next_state u_nxt (
        .cur_state (cur_state),
        .is_load   (is_load),
        .nxt_state (nxt_state)
    );

    fls_state_reg u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_state (nxt_state),
        .cur_state (cur_state)
    );

    fls_ctl_decode u_dec (
        .cur_state (cur_state),
        .ctl       (ctl)
    );

    // Command bundle to ports
    assign alu_fn          = ctl.alu_fn;
    assign acc_load        = ctl.acc_load;
    assign acc_clear       = ctl.acc_clear;
    assign ir_load         = ctl.ir_load;
    assign pc_inc          = ctl.pc_inc;
    assign pc_load_page    = ctl.pc_load_page;
    assign pc_load_ofs     = ctl.pc_load_ofs;
    assign pc_clear        = ctl.pc_clear;
    assign mar_load_page   = ctl.mar_load_page;
    assign mar_load_ofs    = ctl.mar_load_ofs;
    assign sr_load         = ctl.sr_load;
    assign sr_carry_flip   = ctl.sr_carry_flip;
    assign pc_to_page_bus  = ctl.pc_to_page_bus;
    assign ir_to_page_bus  = ctl.ir_to_page_bus;
    assign pc_to_ofs_bus   = ctl.pc_to_ofs_bus;
    assign ibus_to_ofs_bus = ctl.ibus_to_ofs_bus;
    assign pc_ofs_to_ibus  = ctl.pc_ofs_to_ibus;
    assign alu_to_ibus     = ctl.alu_to_ibus;
    assign xbus_to_ibus    = ctl.xbus_to_ibus;
    assign mar_to_abus     = ctl.mar_to_abus;
    assign ibus_to_xbus    = ctl.ibus_to_xbus;
    assign shift_left      = ctl.shift_left;
    assign shift_right     = ctl.shift_right;
    assign mem_read        = ctl.mem_read;

    // Bus exclusivity on the three shared buses (R9)
    assert_page_bus_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_to_page_bus, ir_to_page_bus}));
    assert_ofs_bus_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_to_ofs_bus, ibus_to_ofs_bus}));
    assert_ibus_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pc_ofs_to_ibus, alu_to_ibus, xbus_to_ibus}));

    // Shifter never engaged by this sequence (R8)
    assert_no_shift_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_left || shift_right));

    // A memory read always has an address on the bus (R3)
    assert_read_has_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_read |-> mar_to_abus);

    // An increment step is always followed by a read step (R2)
    assert_inc_then_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_inc |=> (mem_read && mar_to_abus));

    // A load opcode leads to the pointer read with the page taken from the instruction (R4)
    assert_load_branch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_load && (ir_word[IR_W-1:OPC_LSB] == LOAD_CODE)) |=> ##1 ir_to_page_bus);

    // The operand step returns to fetch step 1 (R7)
    assert_operand_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_load |=> (pc_inc && pc_to_page_bus));

endmodule

// File: tb/fetch_lda_seq_tb.sv
// Scoreboard bench: a driver applies inputs on the falling edge and
// queues the command vector expected after the next rising edge. A
// monitor compares the outputs shortly after each rising edge.
module fetch_lda_seq_tb;

    typedef struct {
        logic [25:0] exp;
        string       req;
    } exp_item_t;

    // Bit positions of the observed vector
    localparam int B_RD = 0, B_SHR = 1, B_SHL = 2, B_I2X = 3, B_M2A = 4;
    localparam int B_X2I = 5, B_A2I = 6, B_P2I = 7, B_I2O = 8, B_P2O = 9;
    localparam int B_IR2PG = 10, B_PC2PG = 11, B_CFLIP = 12, B_SRLD = 13;
    localparam int B_MLO = 14, B_MLP = 15, B_PCCLR = 16, B_PLO = 17;
    localparam int B_PLP = 18, B_INC = 19, B_IRLD = 20, B_ACLR = 21, B_ALD = 22;
    localparam logic [25:0] PASS_A = 26'(3'b100) << 23;

    localparam logic [25:0] EXP_CLR = 26'd1 << B_PCCLR;
    localparam logic [25:0] EXP_ADR = (26'd1 << B_PC2PG) | (26'd1 << B_PC2O_FIX());
    localparam logic [25:0] EXP_FRD = (26'd1 << B_M2A) | (26'd1 << B_RD) |
                                      (26'd1 << B_X2I) | (26'd1 << B_IRLD) | PASS_A;
    localparam logic [25:0] EXP_PRD = (26'd1 << B_M2A) | (26'd1 << B_RD) |
                                      (26'd1 << B_X2I) | (26'd1 << B_I2O) |
                                      (26'd1 << B_IR2PG) | (26'd1 << B_MLP) |
                                      (26'd1 << B_MLO);
    localparam logic [25:0] EXP_OPR = (26'd1 << B_M2A) | (26'd1 << B_RD) |
                                      (26'd1 << B_X2I) | (26'd1 << B_ALD) | PASS_A;

    function automatic int B_PC2O_FIX();
        return B_P2O;
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ir_word = 8'h00;
    logic [3:0]  flags = 4'h0;
    logic [2:0]  alu_fn;
    logic acc_load, acc_clear, ir_load, pc_inc, pc_load_page, pc_load_ofs;
    logic pc_clear, mar_load_page, mar_load_ofs, sr_load, sr_carry_flip;
    logic pc_to_page_bus, ir_to_page_bus, pc_to_ofs_bus, ibus_to_ofs_bus;
    logic pc_ofs_to_ibus, alu_to_ibus, xbus_to_ibus, mar_to_abus, ibus_to_xbus;
    logic shift_left, shift_right, mem_read;

    exp_item_t sb_q[$];
    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    fetch_lda_seq u_dut (
        .clk(clk), .rst_n(rst_n), .ir_word(ir_word), .flags(flags),
        .alu_fn(alu_fn), .acc_load(acc_load), .acc_clear(acc_clear),
        .ir_load(ir_load), .pc_inc(pc_inc), .pc_load_page(pc_load_page),
        .pc_load_ofs(pc_load_ofs), .pc_clear(pc_clear),
        .mar_load_page(mar_load_page), .mar_load_ofs(mar_load_ofs),
        .sr_load(sr_load), .sr_carry_flip(sr_carry_flip),
        .pc_to_page_bus(pc_to_page_bus), .ir_to_page_bus(ir_to_page_bus),
        .pc_to_ofs_bus(pc_to_ofs_bus), .ibus_to_ofs_bus(ibus_to_ofs_bus),
        .pc_ofs_to_ibus(pc_ofs_to_ibus), .alu_to_ibus(alu_to_ibus),
        .xbus_to_ibus(xbus_to_ibus), .mar_to_abus(mar_to_abus),
        .ibus_to_xbus(ibus_to_xbus), .shift_left(shift_left),
        .shift_right(shift_right), .mem_read(mem_read)
    );

    logic [25:0] obs;
    assign obs = {alu_fn, acc_load, acc_clear, ir_load, pc_inc, pc_load_page,
                  pc_load_ofs, pc_clear, mar_load_page, mar_load_ofs, sr_load,
                  sr_carry_flip, pc_to_page_bus, ir_to_page_bus, pc_to_ofs_bus,
                  ibus_to_ofs_bus, pc_ofs_to_ibus, alu_to_ibus, xbus_to_ibus,
                  mar_to_abus, ibus_to_xbus, shift_left, shift_right, mem_read};

    // Driver: apply inputs for one edge and queue the vector expected after it
    task automatic step(input logic rst, input logic [7:0] ir,
                        input logic [3:0] flg, input logic [25:0] exp,
                        input string req);
        exp_item_t it;
        @(negedge clk);
        rst_n   = rst;
        ir_word = ir;
        flags   = flg;
        it.exp  = exp;
        it.req  = req;
        sb_q.push_back(it);
    endtask

    // One instruction starting from fetch step 1; only the decision edge sees ir
    task automatic run_instr(input logic [7:0] ir, input logic [3:0] flg);
        step(1'b1, ~ir, flg, EXP_FRD, "R3");
        if (ir[7:4] == 4'h0) begin
            step(1'b1, ir, ~flg, EXP_ADR | (26'd1 << B_MLP) | (26'd1 << B_MLO) |
                 (26'd1 << B_INC), "R4 R5");
            step(1'b1, 8'hFF, flg, EXP_PRD, "R6");
            step(1'b1, {ir[3:0], ir[7:4]}, flg ^ 4'h5, EXP_OPR, "R7");
            step(1'b1, 8'hA5, flg, FETCH1, "R7 R10");
        end else begin
            step(1'b1, ir, ~flg, FETCH1, "R4");
        end
    endtask

    localparam logic [25:0] FETCH1 = EXP_ADR | (26'd1 << B_MLP) |
                                     (26'd1 << B_MLO) | (26'd1 << B_INC);

    // Monitor: compare outputs one time unit after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_item_t it;
                it = sb_q.pop_front();
                n_vec++;
                if (obs !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: outputs %h expected %h at %0t",
                             it.req, obs, it.exp, $time);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        // R1: reset state, held for several edges
        step(1'b0, 8'h00, 4'h0, EXP_CLR, "R1");
        step(1'b0, 8'h37, 4'hF, EXP_CLR, "R1");
        step(1'b0, 8'h00, 4'h3, EXP_CLR, "R1");
        // R1 R2: release enters fetch step 1
        step(1'b1, 8'h00, 4'h0, FETCH1, "R1 R2");

        // R4 R5 R6 R7: load with various low nibbles and flags (R10)
        run_instr(8'h05, 4'h0);
        run_instr(8'h0F, 4'hF);
        run_instr(8'h00, 4'h9);
        // R4: opcode neighbours of the load code
        run_instr(8'h10, 4'h0);
        run_instr(8'hF0, 4'hA);
        run_instr(8'h35, 4'h6);
        // back-to-back loads
        run_instr(8'h0A, 4'h1);
        run_instr(8'h0A, 4'hE);

        // R1: reset cutting into a load after pointer step 1
        step(1'b1, 8'hFF, 4'h0, EXP_FRD, "R3");
        step(1'b1, 8'h03, 4'h0, FETCH1, "R4 R5");
        step(1'b0, 8'h03, 4'h0, EXP_CLR, "R1");
        step(1'b1, 8'h03, 4'h0, FETCH1, "R1 R2");

        // R8 R9 R10: a sweep of opcodes and flags
        for (int i = 0; i < 40; i++) begin
            run_instr(8'((i * 37) & 8'hFF), 4'(i));
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule